// File: doc/BRIEF.md
# Hash Offload Control Register Block

This block is the software-facing register file of a hash offload engine. A 32-bit write port with byte offsets inside a 4 KiB window holds the source address, destination address, source length, hash command and status words, plus a cipher command word that is stored but starts nothing. Reads are combinational from the byte offset on the same bus.

A command write is decoded into an algorithm code. If the selection is legal and no operation is running, the block sends a one-cycle start strobe to the datapath. The strobe comes with the algorithm code, the masked addresses, the length and the scatter-gather select. When the datapath returns done, the completion flag in the status word is set. The interrupt line is raised only if the command word enables it. Software clears the flag, and with it the interrupt, by writing a one to the flag's position. HMAC and cascaded command modes are not executed. They only drive an unsupported-mode output, and decode goes on regardless.

Top module: `hashreg_block`

## Requirements
- R1: After reset every register reads 0, and start_o, irq_o and unsup_o are low.
- R2: Write masks: source address keeps 0x7FFFFFFF, destination address keeps 0x7FFFFFF8 (8-byte aligned), length keeps 0x0FFFFFFF. The full variant keeps 0x00147FFF of the command word, and scatter-gather (command bit 18) drives sg_o. The cipher command word at 0x10 is stored unmasked.
- R3: Offsets other than 0x10, 0x1C, 0x20, 0x24, 0x2C and 0x30 read 0, and writes to them change no register.
- R4: Command bits [6:4] select the algorithm, and algo_o encodes it as MD5=0, SHA1=1, SHA224=2, SHA256=3, SHA384=4, SHA512=5. The field values are 000 MD5, 010 SHA1, 100 SHA224 and 101 SHA256. These four are valid only with bits [12:10] zero.
- R5: With bits [6:4]=110 (SHA-512 family), bits [12:10] pick the variant: 000 SHA512, 001 SHA384, 010 SHA256, 011 SHA224.
- R6: Any other combination of bits [6:4] and [12:10] is invalid and gives no start strobe.
- R7: A valid command write while idle raises start_o for exactly one cycle, in the cycle after the write, with algo_o valid.
- R8: A command write while an operation is running is stored, and reads back, but gives no start strobe.
- R9: done_i while running sets status bit 9 whatever the interrupt enable. irq_o rises only when command bit 9 is set.
- R10: Writing 1 to status bit 9 clears the flag and drops irq_o. Writing 0 there leaves both unchanged.
- R11: unsup_o is high while the stored command has bit 1 set or a nonzero value in bits [8:7], and decode still proceeds.
- R12: The reduced variant keeps only command bits [9:0], so sg_o stays low and the SHA-512 family always decodes as SHA512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 12 | Byte offset of the access |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| done_i | input | 1 | Datapath completion pulse |
| start_o | output | 1 | One-cycle start strobe to the datapath |
| algo_o | output | 3 | Algorithm code of the started operation |
| sg_o | output | 1 | Scatter-gather select from the command word |
| src_addr_o | output | 32 | Masked source address |
| dst_addr_o | output | 32 | Masked destination address |
| src_len_o | output | 32 | Masked source length |
| unsup_o | output | 1 | Unsupported command mode requested |
| irq_o | output | 1 | Completion interrupt |

## Verification
The bench builds two instances side by side, one with FULL_VARIANT=1 and one with FULL_VARIANT=0. The full instance covers the SHA-512 sub-select table, the scatter-gather bit and the wide command mask. The reduced instance shows that the same command bits are dropped and that the family select then collapses to SHA512. Sharing the bus lets one write pattern be compared across the two masks.

// File: rtl/hashreg_pkg.sv
package hashreg_pkg;

  typedef enum logic [2:0] {
    ALG_MD5    = 3'd0,
    ALG_SHA1   = 3'd1,
    ALG_SHA224 = 3'd2,
    ALG_SHA256 = 3'd3,
    ALG_SHA384 = 3'd4,
    ALG_SHA512 = 3'd5
  } hash_alg_e;

  localparam int unsigned OFF_CRYPT  = 32'h10;
  localparam int unsigned OFF_STATUS = 32'h1C;
  localparam int unsigned OFF_SRC    = 32'h20;
  localparam int unsigned OFF_DST    = 32'h24;
  localparam int unsigned OFF_LEN    = 32'h2C;
  localparam int unsigned OFF_CMD    = 32'h30;

  localparam int unsigned DONE_BIT = 9;
  localparam int unsigned IEN_BIT  = 9;
  localparam int unsigned SG_BIT   = 18;

endpackage

// File: rtl/hashreg_alg_dec.sv
module hashreg_alg_dec
  import hashreg_pkg::*;
(
  input  logic [2:0] main_i,
  input  logic [2:0] sub_i,
  output logic       ok_o,
  output hash_alg_e  alg_o
);

  always_comb begin
    ok_o  = 1'b1;
    alg_o = ALG_MD5;
    case (main_i)
      3'b000: begin alg_o = ALG_MD5;    ok_o = (sub_i == 3'b000); end
      3'b010: begin alg_o = ALG_SHA1;   ok_o = (sub_i == 3'b000); end
      3'b100: begin alg_o = ALG_SHA224; ok_o = (sub_i == 3'b000); end
      3'b101: begin alg_o = ALG_SHA256; ok_o = (sub_i == 3'b000); end
      3'b110: begin
        case (sub_i)
          3'b000:  alg_o = ALG_SHA512;
          3'b001:  alg_o = ALG_SHA384;
          3'b010:  alg_o = ALG_SHA256;
          3'b011:  alg_o = ALG_SHA224;
          default: ok_o  = 1'b0;
        endcase
      end
      default: ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/hashreg_seq.sv
module hashreg_seq
  import hashreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      go_i,
  input  logic      go_ok_i,
  input  hash_alg_e go_alg_i,
  input  logic      ien_i,
  input  logic      done_i,
  input  logic      clr_i,
  output logic      start_o,
  output hash_alg_e alg_o,
  output logic      flag_o,
  output logic      irq_o
);

  logic      busy_q, busy_n;
  logic      start_q, start_n;
  logic      flag_q, flag_n;
  logic      irq_q, irq_n;
  hash_alg_e alg_q, alg_n;
  logic      finish;

  assign finish = busy_q & done_i;

  always_comb begin
    start_n = go_i & go_ok_i & ~busy_q;
    busy_n  = busy_q;
    if (finish)  busy_n = 1'b0;
    if (start_n) busy_n = 1'b1;
    alg_n = start_n ? go_alg_i : alg_q;
    flag_n = flag_q;
    irq_n  = irq_q;
    if (clr_i) begin
      flag_n = 1'b0;
      if (flag_q) irq_n = 1'b0;
    end
    if (finish) begin
      flag_n = 1'b1;
      if (ien_i) irq_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
      alg_q   <= ALG_MD5;
    end else begin
      busy_q  <= busy_n;
      start_q <= start_n;
      flag_q  <= flag_n;
      irq_q   <= irq_n;
      alg_q   <= alg_n;
    end
  end

  assign start_o = start_q;
  assign alg_o   = alg_q;
  assign flag_o  = flag_q;
  assign irq_o   = irq_q;

  // R7
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_i) |=> !start_q);

  // R9
  done_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && done_i) |=> flag_q);

  // R9
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> flag_q);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_q) |-> $past(clr_i));

endmodule

// File: rtl/hashreg_block.sv
module hashreg_block
  import hashreg_pkg::*;
#(
  parameter bit          FULL_VARIANT = 1'b1,
  parameter int unsigned ADDR_W       = 12,
  parameter int unsigned DATA_W       = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              done_i,
  output logic              start_o,
  output logic [2:0]        algo_o,
  output logic              sg_o,
  output logic [DATA_W-1:0] src_addr_o,
  output logic [DATA_W-1:0] dst_addr_o,
  output logic [DATA_W-1:0] src_len_o,
  output logic              unsup_o,
  output logic              irq_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] SRC_MASK = DATA_W'(32'h7FFF_FFFF);
  localparam logic [DATA_W-1:0] DST_MASK = DATA_W'(32'h7FFF_FFF8);
  localparam logic [DATA_W-1:0] LEN_MASK = DATA_W'(32'h0FFF_FFFF);
  localparam logic [DATA_W-1:0] CMD_MASK =
    FULL_VARIANT ? DATA_W'(32'h0014_7FFF) : DATA_W'(32'h0000_03FF);

  localparam logic [IDX_W-1:0] I_CRYPT  = IDX_W'(OFF_CRYPT  >> 2);
  localparam logic [IDX_W-1:0] I_STATUS = IDX_W'(OFF_STATUS >> 2);
  localparam logic [IDX_W-1:0] I_SRC    = IDX_W'(OFF_SRC    >> 2);
  localparam logic [IDX_W-1:0] I_DST    = IDX_W'(OFF_DST    >> 2);
  localparam logic [IDX_W-1:0] I_LEN    = IDX_W'(OFF_LEN    >> 2);
  localparam logic [IDX_W-1:0] I_CMD    = IDX_W'(OFF_CMD    >> 2);

  logic [IDX_W-1:0]  idx;
  logic              we_crypt, we_status, we_src, we_dst, we_len, we_cmd;
  logic [DATA_W-1:0] crypt_q, src_q, dst_q, len_q, cmd_q;
  logic [DATA_W-1:0] cmd_wr_val;
  logic              dec_ok;
  hash_alg_e         dec_alg;
  hash_alg_e         run_alg;
  logic              flag;

  assign idx       = addr_i[ADDR_W-1:2];
  assign we_crypt  = wr_en_i & (idx == I_CRYPT);
  assign we_status = wr_en_i & (idx == I_STATUS);
  assign we_src    = wr_en_i & (idx == I_SRC);
  assign we_dst    = wr_en_i & (idx == I_DST);
  assign we_len    = wr_en_i & (idx == I_LEN);
  assign we_cmd    = wr_en_i & (idx == I_CMD);
  assign cmd_wr_val = wdata_i & CMD_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crypt_q <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      len_q   <= '0;
      cmd_q   <= '0;
    end else begin
      if (we_crypt) crypt_q <= wdata_i;
      if (we_src)   src_q   <= wdata_i & SRC_MASK;
      if (we_dst)   dst_q   <= wdata_i & DST_MASK;
      if (we_len)   len_q   <= wdata_i & LEN_MASK;
      if (we_cmd)   cmd_q   <= cmd_wr_val;
    end
  end

  hashreg_alg_dec u_dec (
    .main_i (cmd_wr_val[6:4]),
    .sub_i  (cmd_wr_val[12:10]),
    .ok_o   (dec_ok),
    .alg_o  (dec_alg)
  );

  hashreg_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go_i     (we_cmd),
    .go_ok_i  (dec_ok),
    .go_alg_i (dec_alg),
    .ien_i    (cmd_q[IEN_BIT]),
    .done_i   (done_i),
    .clr_i    (we_status & wdata_i[DONE_BIT]),
    .start_o  (start_o),
    .alg_o    (run_alg),
    .flag_o   (flag),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    case (idx)
      I_CRYPT:  rdata_o = crypt_q;
      I_STATUS: rdata_o[DONE_BIT] = flag;
      I_SRC:    rdata_o = src_q;
      I_DST:    rdata_o = dst_q;
      I_LEN:    rdata_o = len_q;
      I_CMD:    rdata_o = cmd_q;
      default:  rdata_o = '0;
    endcase
  end

  assign algo_o     = run_alg;
  assign sg_o       = cmd_q[SG_BIT];
  assign src_addr_o = src_q;
  assign dst_addr_o = dst_q;
  assign src_len_o  = len_q;
  assign unsup_o    = cmd_q[1] | cmd_q[7] | cmd_q[8];

endmodule

// File: tb/hashreg_block_tb.sv
`timescale 1ns/1ps
module hashreg_block_tb_top;

  logic        clk;
  logic        rst_n;
  logic        wr_f, wr_r;
  logic [11:0] addr;
  logic [31:0] wdata;
  logic        done_f, done_r;
  logic [31:0] rdata_f, rdata_r;
  logic        start_f, start_r, sg_f, sg_r, unsup_f, unsup_r, irq_f, irq_r;
  logic [2:0]  algo_f, algo_r;
  logic [31:0] src_f, dst_f, len_f, src_r, dst_r, len_r;
  int          nchk, nfail;

  // {cmd[31:0], valid, algo[2:0], unsup}
  localparam int NV = 14;
  localparam logic [36:0] VEC [NV] = '{
    {32'h0000_0000, 1'b1, 3'd0, 1'b0},
    {32'h0000_0020, 1'b1, 3'd1, 1'b0},
    {32'h0000_0040, 1'b1, 3'd2, 1'b0},
    {32'h0000_0050, 1'b1, 3'd3, 1'b0},
    {32'h0000_0060, 1'b1, 3'd5, 1'b0},
    {32'h0000_0460, 1'b1, 3'd4, 1'b0},
    {32'h0000_0860, 1'b1, 3'd3, 1'b0},
    {32'h0000_0C60, 1'b1, 3'd2, 1'b0},
    {32'h0000_1060, 1'b0, 3'd0, 1'b0},
    {32'h0000_0010, 1'b0, 3'd0, 1'b0},
    {32'h0000_0070, 1'b0, 3'd0, 1'b0},
    {32'h0000_0420, 1'b0, 3'd0, 1'b0},
    {32'h0000_0180, 1'b1, 3'd0, 1'b1},
    {32'h0000_0022, 1'b1, 3'd1, 1'b1}
  };

  hashreg_block #(.FULL_VARIANT(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_f), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_f), .done_i(done_f), .start_o(start_f), .algo_o(algo_f),
    .sg_o(sg_f), .src_addr_o(src_f), .dst_addr_o(dst_f), .src_len_o(len_f),
    .unsup_o(unsup_f), .irq_o(irq_f));

  hashreg_block #(.FULL_VARIANT(1'b0)) dut_red_i (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_r), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata_r), .done_i(done_r), .start_o(start_r), .algo_o(algo_r),
    .sg_o(sg_r), .src_addr_o(src_r), .dst_addr_o(dst_r), .src_len_o(len_r),
    .unsup_o(unsup_r), .irq_o(irq_r));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit red, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (red) wr_r = 1'b1; else wr_f = 1'b1;
    @(negedge clk);
    wr_f = 1'b0; wr_r = 1'b0;
  endtask

  task automatic rd(input bit red, input logic [11:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = red ? rdata_r : rdata_f;
  endtask

  task automatic pulse_done(input bit red);
    @(negedge clk);
    if (red) done_r = 1'b1; else done_f = 1'b1;
    @(negedge clk);
    done_f = 1'b0; done_r = 1'b0;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] v;
    nchk = 0; nfail = 0;
    rst_n = 1'b0; wr_f = 1'b0; wr_r = 1'b0; done_f = 1'b0; done_r = 1'b0;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(0, 12'h10, v); chk("R1 crypt", v, 0);
    rd(0, 12'h1C, v); chk("R1 status", v, 0);
    rd(0, 12'h20, v); chk("R1 src", v, 0);
    rd(0, 12'h24, v); chk("R1 dst", v, 0);
    rd(0, 12'h2C, v); chk("R1 len", v, 0);
    rd(0, 12'h30, v); chk("R1 cmd", v, 0);
    chk("R1 outs", {29'd0, start_f, irq_f, unsup_f}, 0);

    // R2 masks
    wr(0, 12'h20, 32'hFFFF_FFFF); rd(0, 12'h20, v); chk("R2 src", v, 32'h7FFF_FFFF);
    chk("R2 src port", src_f, 32'h7FFF_FFFF);
    wr(0, 12'h24, 32'hFFFF_FFFF); rd(0, 12'h24, v); chk("R2 dst", v, 32'h7FFF_FFF8);
    wr(0, 12'h2C, 32'hFFFF_FFFF); rd(0, 12'h2C, v); chk("R2 len", v, 32'h0FFF_FFFF);
    chk("R2 len port", len_f, 32'h0FFF_FFFF);
    wr(0, 12'h10, 32'hDEAD_BEEF); rd(0, 12'h10, v); chk("R2 crypt", v, 32'hDEAD_BEEF);
    wr(0, 12'h30, 32'hFFFF_FFFF);
    chk("R6 all-ones no start", {31'd0, start_f}, 0);
    rd(0, 12'h30, v); chk("R2 cmd mask", v, 32'h0014_7FFF);
    chk("R2 sg", {31'd0, sg_f}, 1);

    // R3 unmapped
    wr(0, 12'h40, 32'hFFFF_FFFF); rd(0, 12'h40, v); chk("R3 unmapped 0x40", v, 0);
    wr(0, 12'h14, 32'h1234_5678); rd(0, 12'h14, v); chk("R3 unmapped 0x14", v, 0);
    rd(0, 12'h20, v); chk("R3 src untouched", v, 32'h7FFF_FFFF);
    rd(0, 12'h2C, v); chk("R3 len untouched", v, 32'h0FFF_FFFF);

    // R4 R5 R6 R11 vector table
    for (int i = 0; i < NV; i++) begin
      wr(0, 12'h30, VEC[i][36:5]);
      chk($sformatf("R7 R6 start vec%0d", i), {31'd0, start_f}, {31'd0, VEC[i][4]});
      if (VEC[i][4]) chk($sformatf("R4 R5 algo vec%0d", i), {29'd0, algo_f}, {29'd0, VEC[i][3:1]});
      chk($sformatf("R11 unsup vec%0d", i), {31'd0, unsup_f}, {31'd0, VEC[i][0]});
      pulse_done(0);
      rd(0, 12'h1C, v);
      chk($sformatf("R9 status vec%0d", i), v, VEC[i][4] ? 32'h200 : 32'h0);
      wr(0, 12'h1C, 32'h200);
    end

    // R8 busy blocks start, command still stored
    wr(0, 12'h30, 32'h20);
    chk("R7 start", {31'd0, start_f}, 1);
    @(negedge clk);
    chk("R7 one cycle", {31'd0, start_f}, 0);
    wr(0, 12'h30, 32'h40);
    chk("R8 no start busy", {31'd0, start_f}, 0);
    rd(0, 12'h30, v); chk("R8 cmd stored", v, 32'h40);
    pulse_done(0);
    rd(0, 12'h1C, v); chk("R9 flag w/o ien", v, 32'h200);
    chk("R9 no irq w/o ien", {31'd0, irq_f}, 0);
    wr(0, 12'h1C, 32'h0);
    rd(0, 12'h1C, v); chk("R10 write 0 keeps", v, 32'h200);
    wr(0, 12'h1C, 32'h200);
    rd(0, 12'h1C, v); chk("R10 w1c", v, 0);

    // R9 R10 interrupt
    wr(0, 12'h30, 32'h220);
    chk("R7 start ien", {31'd0, start_f}, 1);
    chk("R9 irq before done", {31'd0, irq_f}, 0);
    pulse_done(0);
    chk("R9 irq raised", {31'd0, irq_f}, 1);
    wr(0, 12'h1C, 32'h0);
    chk("R10 irq kept", {31'd0, irq_f}, 1);
    wr(0, 12'h1C, 32'h200);
    chk("R10 irq dropped", {31'd0, irq_f}, 0);
    rd(0, 12'h1C, v); chk("R10 flag cleared", v, 0);

    // R12 reduced variant
    wr(1, 12'h30, 32'h0014_1C60);
    chk("R12 start", {31'd0, start_r}, 1);
    chk("R12 algo sha512", {29'd0, algo_r}, 32'd5);
    rd(1, 12'h30, v); chk("R12 cmd", v, 32'h60);
    chk("R12 sg", {31'd0, sg_r}, 0);
    pulse_done(1);
    wr(1, 12'h30, 32'hFFFF_FFFF);
    chk("R12 invalid no start", {31'd0, start_r}, 0);
    rd(1, 12'h30, v); chk("R12 cmd mask", v, 32'h3FF);

    summary();
    $finish;
  end

endmodule